// File: doc/BRIEF.md
# Polyphase Subfilter Bank Datapath

This block is the multiply-accumulate core of a five-path polyphase channelizer. It holds a bank of sample delay lines (one row per subfilter, six taps per row) and a bank of prototype-filter coefficients of the same shape. The 30 coefficients of the low-pass prototype are split so that each of the five rows holds six taps. An external scheduler pushes each input sample into a chosen row. Only that row's delay line shifts. Coefficients are loaded through a small write port.

When the scheduler raises the output strobe, it also supplies a rotation offset, which is the residue of the data time-origin modulo five. Data row r is then paired with coefficient row (r + offset) mod 5. The block computes all five inner products at once, using one multiply-accumulator per row stepping through the taps. It rounds each sum and presents the five subfilter outputs side by side for a following transform stage. The data stays in place and the coefficient rows rotate, so the scheduler can realise any stride without moving data. Offset 0 gives the fixed assignment of a maximally decimated bank.

Top module: `pfb_subfilter_bank`

## Requirements
- R1: After reset, busy and outValid are 0 and every field of outData is 0. Both banks are cleared.
- R2: A sample write (sampleValid high, busy low) to row sampleRow in 0..4 shifts only that row one tap: tap t takes tap t-1 and tap 0 takes sampleData. The other rows keep their contents. Row indices 5..7 change nothing.
- R3: A coefficient write (coefWrite high, busy low) stores coefData at coefRow, coefTap. A row index of 5 or more, or a tap index of 6 or more, changes nothing.
- R4: For a computation started with offset k, row r's result uses coefficient row (r + (k mod 5)) mod 5. The offset is captured on the accepted strobe, and values 5..7 act as 0..2.
- R5: With offset 0, data row r is paired with coefficient row r.
- R6: Each row result is the exact signed sum of six 16x16 products. It is divided by 2^15, rounded half toward plus infinity, and saturated to the 18-bit signed range [-131072, 131071]. Row r occupies outData[18r+17:18r].
- R7: A strobe sampled with busy low is accepted. busy is high from the next cycle. outValid is a single-cycle pulse on the sixth rising edge after the accepted edge, and busy falls on that same edge.
- R8: A strobe sampled while busy is high is ignored. It neither restarts the computation nor produces an extra valid pulse.
- R9: Sample and coefficient writes sampled while busy is high are ignored.
- R10: outData holds its value in every cycle in which outValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Push sampleData into row sampleRow |
| sampleRow | input | 3 | Target row of the sample push |
| sampleData | input | 16 | Signed input sample |
| coefWrite | input | 1 | Coefficient write enable |
| coefRow | input | 3 | Coefficient row index |
| coefTap | input | 3 | Coefficient tap index |
| coefData | input | 16 | Signed coefficient value |
| outStrobe | input | 1 | Start computation of one output set |
| rotOffset | input | 3 | Coefficient rotation offset, used with the strobe |
| busy | output | 1 | Computation in progress |
| outValid | output | 1 | One-cycle pulse: outData holds a new result set |
| outData | output | 90 | Five 18-bit signed subfilter outputs, row 0 in the low bits |

## Verification
The strobe is sampled on a rising edge. busy must read high at the falling edge after that edge. outValid must stay low at the next five falling edges and read high, with busy low, at the sixth, which is where all five row results are compared. The bench drives every input just after a falling edge and reads every output at falling edges, so each check falls exactly on the cycle that R7 fixes. The ignore rules for writes made while busy are checked through the results of the next computation. The hold rule is checked by rereading outData several cycles after new writes.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  localparam int CTRL_TAP_W = 4;

  typedef struct packed {
    logic                  start;
    logic                  idle;
    logic                  mac;
    logic                  first;
    logic                  last;
    logic [CTRL_TAP_W-1:0] tap;
  } pfb_ctrl_t;
endpackage

// File: rtl/pfb_ctrl.sv
module pfb_ctrl
  import pfb_pkg::*;
#(
  parameter int TAPS = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      outStrobe,
  output pfb_ctrl_t ctl,
  output logic      busy,
  output logic      outValid
);
  localparam logic [CTRL_TAP_W-1:0] LAST_TAP = CTRL_TAP_W'(TAPS - 1);

  logic [CTRL_TAP_W-1:0] tapCnt;
  logic                  start;

  assign start = outStrobe && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      tapCnt   <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        tapCnt <= '0;
      end else if (busy) begin
        if (tapCnt == LAST_TAP) begin
          busy     <= 1'b0;
          outValid <= 1'b1;
        end else begin
          tapCnt <= tapCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctl.start = start;
    ctl.idle  = !busy;
    ctl.mac   = busy;
    ctl.first = busy && (tapCnt == '0);
    ctl.last  = busy && (tapCnt == LAST_TAP);
    ctl.tap   = tapCnt;
  end
endmodule

// File: rtl/pfb_row_mac.sv
module pfb_row_mac #(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int ACC_W     = 38,
  parameter int OUT_W     = 18,
  parameter int OUT_SHIFT = 15
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     mac,
  input  logic                     first,
  input  logic                     last,
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [OUT_W-1:0]  rowOut
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (OUT_SHIFT - 1);
  localparam logic signed [ACC_W-1:0] OMAX = (ACC_W'(1) << (OUT_W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] OMIN = -OMAX - ACC_W'(1);

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  accBase;
  logic signed [ACC_W-1:0]  sum;
  logic signed [ACC_W-1:0]  rnd;
  logic signed [ACC_W-1:0]  shf;
  logic signed [OUT_W-1:0]  satOut;

  always_comb begin
    prod    = sample * coef;
    accBase = first ? '0 : acc;
    sum     = accBase + ACC_W'(prod);
    rnd     = sum + HALF;
    shf     = rnd >>> OUT_SHIFT;
    if (shf > OMAX)      satOut = OUT_W'(OMAX);
    else if (shf < OMIN) satOut = OUT_W'(OMIN);
    else                 satOut = OUT_W'(shf);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc    <= '0;
      rowOut <= '0;
    end else if (mac) begin
      acc <= sum;
      if (last) rowOut <= satOut;
    end
  end
endmodule

// File: rtl/pfb_datapath.sv
module pfb_datapath
  import pfb_pkg::*;
#(
  parameter int ROWS      = 5,
  parameter int TAPS      = 6,
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int ACC_W     = 38,
  parameter int OUT_W     = 18,
  parameter int OUT_SHIFT = 15,
  parameter int ROW_IW    = 3,
  parameter int TAP_IW    = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pfb_ctrl_t               ctl,
  input  logic                    sampleValid,
  input  logic [ROW_IW-1:0]       sampleRow,
  input  logic [DATA_W-1:0]       sampleData,
  input  logic                    coefWrite,
  input  logic [ROW_IW-1:0]       coefRow,
  input  logic [TAP_IW-1:0]       coefTap,
  input  logic [COEF_W-1:0]       coefData,
  input  logic [ROW_IW-1:0]       rotOffset,
  output logic [ROWS*OUT_W-1:0]   outData
);
  logic signed [DATA_W-1:0] dataBank [ROWS][TAPS];
  logic signed [COEF_W-1:0] coefBank [ROWS][TAPS];
  logic [ROW_IW-1:0]        offReg;

  // Delay lines: only the addressed row moves.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++)
        for (int t = 0; t < TAPS; t++)
          dataBank[r][t] <= '0;
    end else if (sampleValid && ctl.idle) begin
      for (int r = 0; r < ROWS; r++) begin
        if (sampleRow == ROW_IW'(r)) begin
          for (int t = TAPS - 1; t > 0; t--)
            dataBank[r][t] <= dataBank[r][t-1];
          dataBank[r][0] <= sampleData;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++)
        for (int t = 0; t < TAPS; t++)
          coefBank[r][t] <= '0;
    end else if (coefWrite && ctl.idle) begin
      for (int r = 0; r < ROWS; r++)
        for (int t = 0; t < TAPS; t++)
          if (coefRow == ROW_IW'(r) && coefTap == TAP_IW'(t))
            coefBank[r][t] <= coefData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          offReg <= '0;
    else if (ctl.start) offReg <= ROW_IW'(int'(rotOffset) % ROWS);
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic signed [DATA_W-1:0] selSample;
    logic signed [COEF_W-1:0] selCoef;
    logic signed [OUT_W-1:0]  rowOut;
    int                       cIdx;

    always_comb begin
      cIdx      = (r + int'(offReg)) % ROWS;
      selSample = '0;
      selCoef   = '0;
      for (int t = 0; t < TAPS; t++) begin
        if (ctl.tap == CTRL_TAP_W'(t)) begin
          selSample = dataBank[r][t];
          for (int c = 0; c < ROWS; c++)
            if (cIdx == c) selCoef = coefBank[c][t];
        end
      end
    end

    pfb_row_mac #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
      .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT)
    ) u_mac (
      .clk(clk), .rstN(rstN), .mac(ctl.mac), .first(ctl.first), .last(ctl.last),
      .sample(selSample), .coef(selCoef), .rowOut(rowOut)
    );

    assign outData[r*OUT_W +: OUT_W] = rowOut;
  end
endmodule

// File: rtl/pfb_subfilter_bank.sv
module pfb_subfilter_bank
  import pfb_pkg::*;
#(
  parameter int ROWS      = 5,
  parameter int TAPS      = 6,
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int ACC_W     = 38,
  parameter int OUT_W     = 18,
  parameter int OUT_SHIFT = 15,
  localparam int ROW_IW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int TAP_IW   = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleValid,
  input  logic [ROW_IW-1:0]     sampleRow,
  input  logic [DATA_W-1:0]     sampleData,
  input  logic                  coefWrite,
  input  logic [ROW_IW-1:0]     coefRow,
  input  logic [TAP_IW-1:0]     coefTap,
  input  logic [COEF_W-1:0]     coefData,
  input  logic                  outStrobe,
  input  logic [ROW_IW-1:0]     rotOffset,
  output logic                  busy,
  output logic                  outValid,
  output logic [ROWS*OUT_W-1:0] outData
);
  pfb_ctrl_t ctl;

  pfb_ctrl #(.TAPS(TAPS)) u_ctrl (
    .clk(clk), .rstN(rstN), .outStrobe(outStrobe),
    .ctl(ctl), .busy(busy), .outValid(outValid)
  );

  pfb_datapath #(
    .ROWS(ROWS), .TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W),
    .ACC_W(ACC_W), .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT),
    .ROW_IW(ROW_IW), .TAP_IW(TAP_IW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .sampleValid(sampleValid), .sampleRow(sampleRow), .sampleData(sampleData),
    .coefWrite(coefWrite), .coefRow(coefRow), .coefTap(coefTap), .coefData(coefData),
    .rotOffset(rotOffset), .outData(outData)
  );
endmodule

// File: rtl/pfb_subfilter_bank_sva.sv
module pfb_subfilter_bank_sva #(
  parameter int ROWS  = 5,
  parameter int TAPS  = 6,
  parameter int OUT_W = 18
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  outStrobe,
  input logic                  busy,
  input logic                  outValid,
  input logic [ROWS*OUT_W-1:0] outData
);
  logic [7:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   busyCnt <= '0;
    else if (outStrobe && !busy) busyCnt <= '0;
    else if (busy)               busyCnt <= busyCnt + 1'b1;
  end

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outStrobe && !busy) |=> busy);

  assert_valid_ends_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (!busy && $past(busy)));

  assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (busyCnt == 8'(TAPS)));

  assert_busy_exit_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || outValid));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData));
endmodule

bind pfb_subfilter_bank pfb_subfilter_bank_sva #(
  .ROWS(ROWS), .TAPS(TAPS), .OUT_W(OUT_W)
) u_sva (
  .clk(clk), .rstN(rstN), .outStrobe(outStrobe),
  .busy(busy), .outValid(outValid), .outData(outData)
);

// File: tb/pfb_subfilter_bank_bench.sv
`timescale 1ns/1ps
module pfb_subfilter_bank_bench;
  localparam int ROWS = 5;
  localparam int TAPS = 6;
  localparam int OUT_W = 18;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  sampleValid = 1'b0;
  logic [2:0]            sampleRow = '0;
  logic [15:0]           sampleData = '0;
  logic                  coefWrite = 1'b0;
  logic [2:0]            coefRow = '0;
  logic [2:0]            coefTap = '0;
  logic [15:0]           coefData = '0;
  logic                  outStrobe = 1'b0;
  logic [2:0]            rotOffset = '0;
  logic                  busy;
  logic                  outValid;
  logic [ROWS*OUT_W-1:0] outData;

  int  tests = 0;
  int  fails = 0;
  bit  done = 0;
  int  md [ROWS][TAPS];
  int  mc [ROWS][TAPS];
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  pfb_subfilter_bank u_pfb_subfilter_bank (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleRow(sampleRow),
    .sampleData(sampleData), .coefWrite(coefWrite), .coefRow(coefRow),
    .coefTap(coefTap), .coefData(coefData), .outStrobe(outStrobe),
    .rotOffset(rotOffset), .busy(busy), .outValid(outValid), .outData(outData)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint rowOf(input int r);
    return longint'($signed(outData[r*OUT_W +: OUT_W]));
  endfunction

  function automatic longint expRow(input int r, input int off);
    longint s = 0;
    int c = (r + off % ROWS) % ROWS;
    for (int t = 0; t < TAPS; t++) s += longint'(md[r][t]) * longint'(mc[c][t]);
    s = (s + 16384) >>> 15;
    if (s > 131071) s = 131071;
    if (s < -131072) s = -131072;
    return s;
  endfunction

  task automatic pushSample(input int row, input int val);
    @(negedge clk);
    sampleValid = 1'b1; sampleRow = 3'(row); sampleData = 16'(val);
    @(negedge clk);
    sampleValid = 1'b0;
    if (row < ROWS) begin
      for (int t = TAPS - 1; t > 0; t--) md[row][t] = md[row][t-1];
      md[row][0] = val;
    end
  endtask

  task automatic writeCoef(input int row, input int tap, input int val);
    @(negedge clk);
    coefWrite = 1'b1; coefRow = 3'(row); coefTap = 3'(tap); coefData = 16'(val);
    @(negedge clk);
    coefWrite = 1'b0;
    if (row < ROWS && tap < TAPS) mc[row][tap] = val;
  endtask

  // Strobe accepted on edge E0; valid expected at E6 (R7).
  task automatic runCompute(input int off, input bit poke);
    string tag;
    bit earlyValid = 0;
    @(negedge clk);
    outStrobe = 1'b1; rotOffset = 3'(off);
    @(negedge clk);
    outStrobe = 1'b0;
    chk("R7", "busy after strobe", longint'(busy), 1);
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (outValid) earlyValid = 1;
      if (poke && i == 2) begin
        sampleValid = 1'b1; sampleRow = 3'd1; sampleData = 16'd999;
        coefWrite = 1'b1; coefRow = 3'd0; coefTap = 3'd0; coefData = 16'd12345;
        outStrobe = 1'b1; rotOffset = 3'd3;
      end
      if (poke && i == 3) begin
        sampleValid = 1'b0; coefWrite = 1'b0; outStrobe = 1'b0;
      end
    end
    chk("R7", "valid before sixth edge", longint'(earlyValid), 0);
    @(negedge clk);
    chk("R7", "valid at sixth edge", longint'(outValid), 1);
    chk("R7", "busy low at valid", longint'(busy), 0);
    tag = (off == 0) ? "R5" : "R4";
    for (int r = 0; r < ROWS; r++) chk(tag, $sformatf("row %0d off %0d", r, off), rowOf(r), expRow(r, off));
  endtask

  function automatic int nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[23:8]));
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    longint held [ROWS];
    int vc;
    for (int r = 0; r < ROWS; r++) for (int t = 0; t < TAPS; t++) begin md[r][t] = 0; mc[r][t] = 0; end
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", longint'(busy), 0);
    chk("R1", "valid in reset", longint'(outValid), 0);
    chk("R1", "data in reset", longint'(outData == '0), 1);
    rstN = 1'b1;
    @(negedge clk);
    runCompute(0, 0);   // R1: cleared banks give zero

    // R3: load coefficients, including ignored out-of-range writes
    for (int r = 0; r < ROWS; r++)
      for (int t = 0; t < TAPS; t++)
        writeCoef(r, t, ((r * 6 + t) * 2731 % 8000) - 4000);
    writeCoef(5, 0, 777); writeCoef(0, 6, 777); writeCoef(2, 7, 777); writeCoef(7, 3, 777);

    // R2/R4/R5: sweep load patterns and every offset code
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 14; k++) begin
        vc = nextRand();
        pushSample(int'(seed[27:25]), vc);
      end
      for (int off = 0; off < 8; off++) runCompute(off, 0);
    end

    // R6: half-up rounding
    for (int r = 0; r < ROWS; r++) for (int t = 0; t < TAPS; t++) writeCoef(r, t, 0);
    writeCoef(0, 0, 128);
    for (int t = 0; t < TAPS; t++) pushSample(0, 0);
    pushSample(0, 128);
    runCompute(0, 0);
    chk("R6", "round +0.5 up", rowOf(0), 1);
    pushSample(0, -128);
    runCompute(0, 0);
    chk("R6", "round -0.5 up", rowOf(0), 0);

    // R6: saturation at both ends
    for (int r = 0; r < ROWS; r++) for (int t = 0; t < TAPS; t++) begin
      writeCoef(r, t, -32768);
      pushSample(r, -32768);
    end
    runCompute(2, 0);
    for (int r = 0; r < ROWS; r++) chk("R6", "saturate high", rowOf(r), 131071);
    for (int r = 0; r < ROWS; r++) for (int t = 0; t < TAPS; t++) writeCoef(r, t, 32767);
    runCompute(4, 0);
    for (int r = 0; r < ROWS; r++) chk("R6", "saturate low", rowOf(r), -131072);

    // R8/R9: writes and strobe while busy are ignored
    for (int r = 0; r < ROWS; r++) for (int t = 0; t < TAPS; t++) writeCoef(r, t, (r + 1) * (t - 2) * 300);
    for (int k = 0; k < 12; k++) pushSample(k % ROWS, nextRand());
    runCompute(1, 1);
    vc = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (outValid) vc++;
    end
    chk("R8", "extra valid pulses", vc, 0);
    runCompute(1, 0);   // R9: model never saw the poked writes

    // R10: outputs hold across later writes
    for (int r = 0; r < ROWS; r++) held[r] = rowOf(r);
    pushSample(3, 4321);
    writeCoef(2, 2, -999);
    repeat (3) @(negedge clk);
    for (int r = 0; r < ROWS; r++) chk("R10", $sformatf("hold row %0d", r), rowOf(r), held[r]);
    runCompute(3, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule